// File: doc/BRIEF.md
# Upset-Tolerant Word Transfer Sequencer

This block is the control sequencer of a serial-bus remote terminal. Once a command word has been accepted, a one-cycle `start` pulse and a 3-bit message type hand the message to the sequencer. It then steps through one of three word-transfer paths. The receive path writes incoming words to a buffer and then reports status. The transmit path sends status and then reads and sends data words. The broadcast-transmit path latches status without driving the bus. It drives a buffer request, an encoder strobe, a busy flag, a command-done flag and a status-latch signal. It reacts to word-arrival and encoder-finished handshakes.

The state register is four bits wide and uses fixed binary codes. All sixteen values are decoded explicitly, with no catch-all branch. If an upset lands the register on one of the three unused codes, the block raises an error output and silences every control output in that same cycle. On the following edge it returns to idle. Nothing may replicate or re-encode the register, so that an illegal value always stays visible.

Top module: `xfer_seq`

## Requirements
- R1: After reset the sequencer is idle: `buf_req`, `enc_stb`, `busy`, `cmd_done`, `status_latch` and `fsm_err` are all 0.
- R2: The state code fully determines the outputs. Codes 0 to 12 are legal: 0 is idle, 1 is the decode state and 12 is the final done state. `buf_req` is high in codes 2, 6 and 10, `enc_stb` in codes 4 and 7, `busy` in codes 1 to 11 and `cmd_done` in code 12.
- R3: Codes 13, 14 and 15 are illegal. In such a state `fsm_err` is 1 for exactly one cycle, and the next state is idle.
- R4: While the state holds an illegal code, `buf_req`, `enc_stb`, `busy`, `cmd_done` and `status_latch` are all 0 in that same cycle.
- R5: `msg_sel` is sampled on the edge where `start` is seen in idle, and later changes have no effect. Bit 2 selects broadcast, bit 1 selects transmit and bit 0 selects a data transfer rather than a mode code.
- R6: Receive types (000, 001, 100, 101) enter the first write state. Each word is written with one `buf_req` pulse, and a word that arrives with `last_word` is the final write. A non-broadcast receive then gives one `enc_stb` (status); a broadcast receive gives none.
- R7: Non-broadcast transmit types (010, 011) enter the transmit-status state and give one status `enc_stb`. For 011, each word then takes one `buf_req` read and one `enc_stb`, until `enc_done` arrives with `last_word`.
- R8: Broadcast transmit types (110, 111) enter the message-status state with exactly one `status_latch` pulse and no `buf_req` or `enc_stb`.
- R9: `busy` is high from the cycle after leaving idle until the done state. `cmd_done` is a single-cycle pulse with `busy` low, followed by idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a message (acted on only in idle) |
| msg_sel | input | 3 | Message type: bit2 broadcast, bit1 transmit, bit0 data |
| rx_word | input | 1 | A received word is ready to be written |
| enc_done | input | 1 | The encoder finished the current word |
| last_word | input | 1 | Qualifies `rx_word`/`enc_done` as the final word |
| buf_req | output | 1 | Buffer write or read request |
| enc_stb | output | 1 | Start the encoder on a word |
| busy | output | 1 | Message in progress |
| cmd_done | output | 1 | One-cycle message-complete pulse |
| status_latch | output | 1 | Latch status for a broadcast transmit |
| fsm_err | output | 1 | Illegal state code detected |

## Verification
Every one of the sixteen state codes is deposited into the register after a fresh reset, with all handshakes idle. The combinational outputs must then match the code table, and the error flag must fire for exactly the three unused codes and clear after one edge back to idle. All eight message types are then run at several word counts, with the selector scrambled after `start`. The counts of buffer requests, encoder strobes, latch pulses and busy cycles identify which path was taken. They also show that the type was latched and that broadcast suppresses status.

// File: rtl/xfer_seq.sv
module xfer_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] msg_sel,
  input  logic       rx_word,
  input  logic       enc_done,
  input  logic       last_word,
  output logic       buf_req,
  output logic       enc_stb,
  output logic       busy,
  output logic       cmd_done,
  output logic       status_latch,
  output logic       fsm_err
);
  localparam logic [3:0] S_IDLE  = 4'b0000;
  localparam logic [3:0] S_INIT  = 4'b0001;
  localparam logic [3:0] S_WR0   = 4'b0010;
  localparam logic [3:0] S_RXW   = 4'b0011;
  localparam logic [3:0] S_TXST  = 4'b0100;
  localparam logic [3:0] S_TXSW  = 4'b0101;
  localparam logic [3:0] S_TXRD  = 4'b0110;
  localparam logic [3:0] S_TXDT  = 4'b0111;
  localparam logic [3:0] S_TXDW  = 4'b1000;
  localparam logic [3:0] S_MSTAT = 4'b1001;
  localparam logic [3:0] S_WRL   = 4'b1010;
  localparam logic [3:0] S_RXCK  = 4'b1011;
  localparam logic [3:0] S_DONE  = 4'b1100;
  localparam logic [3:0] S_BAD0  = 4'b1101;
  localparam logic [3:0] S_BAD1  = 4'b1110;
  localparam logic [3:0] S_BAD2  = 4'b1111;

  logic [3:0] state, nxt;
  logic [2:0] sel_q;

  wire is_bc = sel_q[2];
  wire is_tx = sel_q[1];
  wire is_dt = sel_q[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      sel_q <= 3'b000;
    end else begin
      state <= nxt;
      if (state == S_IDLE && start) sel_q <= msg_sel;
    end

  always_comb begin
    nxt          = state;
    buf_req      = 1'b0;
    enc_stb      = 1'b0;
    busy         = 1'b0;
    cmd_done     = 1'b0;
    status_latch = 1'b0;
    fsm_err      = 1'b0;
    case (state)
      S_IDLE:  if (start) nxt = S_INIT;
      S_INIT: begin
        busy = 1'b1;
        case (sel_q)
          3'b000: nxt = S_WR0;
          3'b001: nxt = S_WR0;
          3'b010: nxt = S_TXST;
          3'b011: nxt = S_TXST;
          3'b100: nxt = S_WR0;
          3'b101: nxt = S_WR0;
          3'b110: begin nxt = S_MSTAT; status_latch = 1'b1; end
          3'b111: begin nxt = S_MSTAT; status_latch = 1'b1; end
        endcase
      end
      S_WR0:   begin busy = 1'b1; buf_req = 1'b1; nxt = S_RXW; end
      S_RXW: begin
        busy = 1'b1;
        if (rx_word) nxt = last_word ? S_WRL : S_WR0;
      end
      S_TXST:  begin busy = 1'b1; enc_stb = 1'b1; nxt = S_TXSW; end
      S_TXSW: begin
        busy = 1'b1;
        if (enc_done) nxt = (is_tx && is_dt) ? S_TXRD : S_DONE;
      end
      S_TXRD:  begin busy = 1'b1; buf_req = 1'b1; nxt = S_TXDT; end
      S_TXDT:  begin busy = 1'b1; enc_stb = 1'b1; nxt = S_TXDW; end
      S_TXDW: begin
        busy = 1'b1;
        if (enc_done) nxt = last_word ? S_DONE : S_TXRD;
      end
      S_MSTAT: begin busy = 1'b1; nxt = S_DONE; end
      S_WRL:   begin busy = 1'b1; buf_req = 1'b1; nxt = S_RXCK; end
      S_RXCK:  begin busy = 1'b1; nxt = is_bc ? S_MSTAT : S_TXST; end
      S_DONE:  begin cmd_done = 1'b1; nxt = S_IDLE; end
      S_BAD0:  begin fsm_err = 1'b1; nxt = S_IDLE; end
      S_BAD1:  begin fsm_err = 1'b1; nxt = S_IDLE; end
      S_BAD2:  begin fsm_err = 1'b1; nxt = S_IDLE; end
    endcase
  end

  // R3
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_err |=> !fsm_err && !busy && !buf_req && !enc_stb);
  // R4
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_err |-> !(buf_req || enc_stb || busy || cmd_done || status_latch));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !busy ##1 !cmd_done && !busy);
  // R8
  latch_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_latch |=> !status_latch && busy && !buf_req && !enc_stb);
  // R2
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_req, enc_stb, cmd_done, fsm_err}));
endmodule

// File: tb/xfer_seq_test.sv
module xfer_seq_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start, rx_word, enc_done, last_word;
  logic [2:0] msg_sel;
  logic buf_req, enc_stb, busy, cmd_done, status_latch, fsm_err;

  xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_sel(msg_sel),
    .rx_word(rx_word), .enc_done(enc_done), .last_word(last_word),
    .buf_req(buf_req), .enc_stb(enc_stb), .busy(busy), .cmd_done(cmd_done),
    .status_latch(status_latch), .fsm_err(fsm_err)
  );

  int checks = 0;
  int fails  = 0;
  bit summary_done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; start = 0; msg_sel = 0; rx_word = 0; enc_done = 0; last_word = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run_msg(input logic [2:0] s, input int nw);
    int bufc, encc, latc, busyc, donec, thr;
    int e_buf, e_enc, e_lat, e_busy;
    bufc = 0; encc = 0; latc = 0; busyc = 0; donec = 0;
    if (!s[1]) begin
      thr = nw - 1; e_buf = nw; e_enc = s[2] ? 0 : 1; e_lat = 0;
      e_busy = s[2] ? 2 * nw + 2 : 2 * nw + 3;
    end else if (s[2]) begin
      thr = 0; e_buf = 0; e_enc = 0; e_lat = 1; e_busy = 2;
    end else if (s[0]) begin
      thr = nw; e_buf = nw; e_enc = 1 + nw; e_lat = 0; e_busy = 3 + 3 * nw;
    end else begin
      thr = 0; e_buf = 0; e_enc = 1; e_lat = 0; e_busy = 3;
    end
    start = 1; msg_sel = s; rx_word = 1; enc_done = 1; last_word = 0;
    @(negedge clk);
    start = 0; msg_sel = ~s;
    for (int cyc = 0; cyc < 200; cyc++) begin
      bufc += int'(buf_req);
      encc += int'(enc_stb);
      latc += int'(status_latch);
      if (busy) busyc++;
      if (cmd_done) begin
        donec++;
        chk("R9 busy low in done", int'(busy), 0);
        break;
      end
      last_word = (bufc >= thr);
      @(negedge clk);
    end
    chk($sformatf("R6/R7 buffer requests sel=%0d", s), bufc, e_buf);
    chk($sformatf("R6/R7 encoder strobes sel=%0d", s), encc, e_enc);
    chk($sformatf("R8 latch pulses sel=%0d", s), latc, e_lat);
    chk($sformatf("R5/R9 busy cycles sel=%0d", s), busyc, e_busy);
    chk("R9 done pulse seen", donec, 1);
    rx_word = 0; enc_done = 0; last_word = 0;
    @(negedge clk);
    chk("R9 done lasts one cycle", int'(cmd_done), 0);
    chk("R9 idle after done", int'(busy), 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk("R1 buf_req", int'(buf_req), 0);
    chk("R1 enc_stb", int'(enc_stb), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 cmd_done", int'(cmd_done), 0);
    chk("R1 status_latch", int'(status_latch), 0);
    chk("R1 fsm_err", int'(fsm_err), 0);

    for (int code = 0; code < 16; code++) begin
      bit bad;
      do_reset();
      bad = (code >= 13);
      force uut.state = 4'(code);
      #1;
      release uut.state;
      #1;
      chk($sformatf("R3 err code %0d", code), int'(fsm_err), int'(bad));
      chk($sformatf("R2/R4 buf_req code %0d", code), int'(buf_req),
          int'(code == 2 || code == 6 || code == 10));
      chk($sformatf("R2/R4 enc_stb code %0d", code), int'(enc_stb),
          int'(code == 4 || code == 7));
      chk($sformatf("R2/R4 busy code %0d", code), int'(busy),
          int'(code >= 1 && code <= 11));
      chk($sformatf("R2/R4 cmd_done code %0d", code), int'(cmd_done), int'(code == 12));
      chk($sformatf("R4 latch code %0d", code), int'(status_latch), 0);
      @(negedge clk);
      if (bad) begin
        chk($sformatf("R3 err one cycle code %0d", code), int'(fsm_err), 0);
        chk($sformatf("R3 back to idle code %0d", code),
            int'({buf_req, enc_stb, busy, cmd_done}), 0);
      end
    end

    do_reset();
    for (int s = 0; s < 8; s++)
      for (int k = 1; k <= 3; k++)
        run_msg(3'(s), s[1] ? k : k + 1);

    summary();
    $finish;
  end
endmodule